// File: doc/BRIEF.md
# Interrupt Entry Stack Sequencer

This block carries out the control transfer into an interrupt or exception handler. Each request supplies an event source, an immediate or external vector, a fault/trap flag, the operating mode, a privilege-change flag, the interrupted context and an optional error code. From these the block works out the handler vector and the address of its descriptor-table entry. It then writes the interrupted context onto the handler stack. The writes go out one at a time through a valid/acknowledge write port. When the last write is acknowledged, the block reports the vector, the descriptor address and the final stack pointer.

The stack for a privilege change or a long-mode event comes in on a port. Descriptor fetch, permission checks and task-state reads are left to neighbouring logic. A state machine with three states drives the sequence. ST_IDLE moves to ST_PUSH on *accept*, when a request arrives while not busy. ST_PUSH stays in ST_PUSH on *ack-more*, an acknowledge with items left to write. ST_PUSH moves to ST_DONE on *ack-last*, the acknowledge of the final item. ST_DONE always returns to ST_IDLE on *release*.

Top module: `int_entry_seq`

## Requirements
- R1: The handler vector is 3 for source code 1 (breakpoint) and 4 for source code 2 (overflow check). For source codes 0 (software INT n), 3 (external), 4 (exception) and 5 to 7 (treated as external), the vector is `req_vec`. It is reported on `done_vec`.
- R2: `done_desc_addr` equals `idt_base` plus the vector times the entry size. The entry size is 4 bytes when `mode` is 0 (real), 8 bytes when `mode` is 1 (legacy protected) and 16 bytes when `mode` is 2 or 3 (long).
- R3: With `mode` 0, or `mode` 1 and `priv_change` low, the stack pointer starts at `cur_rsp` and `done_switch` is 0. The writes are flags, then `cur_cs`, then the return pointer. In `mode` 0, `priv_change` has no effect.
- R4: With `mode` 2 or 3, or `mode` 1 and `priv_change` high, the stack pointer starts at `new_rsp` and `done_switch` is 1. The writes are `cur_ss`, `cur_rsp`, flags, `cur_cs` and the return pointer, in that order.
- R5: `err_code` is written as one extra final item only for source code 4 with a vector of 8, 10, 11, 12, 13, 14 or 17. No other source or vector writes it.
- R6: The return pointer written is `cur_rip` for source code 4 with `req_fault` high. In every other case it is `next_rip`.
- R7: Before each write the pointer drops by the slot size: 8 bytes in long mode with `wr_size8` high, otherwise 4 bytes with `wr_size8` low. Each write goes to the decremented pointer. `done_rsp` is the address of the last write. In 4-byte slots `wr_data` carries the item's low 32 bits, with the upper bits zero. Selectors and the error code are zero-extended.
- R8: `wr_valid` stays high with stable `wr_addr`, `wr_data` and `wr_size8` until `wr_ack`. The next item is presented in the cycle after the acknowledge.
- R9: `busy` rises the cycle after acceptance and stays high until `done` has pulsed for exactly one cycle. A request presented while `busy` is high is ignored.
- R10: After reset `busy`, `wr_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_src | input | 3 | Event source code (see R1) |
| req_vec | input | VEC_W | Immediate or supplied vector |
| req_fault | input | 1 | Exception is a fault (retry the instruction) |
| mode | input | 2 | 0 real, 1 legacy protected, 2/3 long |
| priv_change | input | 1 | Handler runs at higher privilege |
| idt_base | input | ADDR_W | Descriptor table base |
| cur_ss | input | SEL_W | Interrupted stack selector |
| cur_rsp | input | ADDR_W | Interrupted stack pointer |
| cur_cs | input | SEL_W | Interrupted code selector |
| cur_rip | input | ADDR_W | Address of the current instruction |
| next_rip | input | ADDR_W | Address of the following instruction |
| cur_flags | input | DATA_W | Flags register |
| err_code | input | ERR_W | Error code |
| new_rsp | input | ADDR_W | Handler stack pointer on a stack switch |
| busy | output | 1 | Sequence in progress |
| wr_valid | output | 1 | Stack write request |
| wr_addr | output | ADDR_W | Stack write address |
| wr_data | output | DATA_W | Stack write data |
| wr_size8 | output | 1 | 1: 8-byte slot, 0: 4-byte slot |
| wr_ack | input | 1 | Write acknowledge |
| done | output | 1 | One-cycle completion pulse |
| done_vec | output | VEC_W | Selected vector |
| done_desc_addr | output | ADDR_W | Descriptor entry address |
| done_rsp | output | ADDR_W | Final stack pointer |
| done_switch | output | 1 | Stack was switched |

## Verification
A new request and the acknowledge of the final stack write can arrive in the same cycle. The bench provokes this by raising `req_valid` exactly on the cycle of the last `wr_ack`, with a different vector. It judges the result by checking that `done_vec` still reports the original vector, and that no further write appears and `busy` stays low in the cycles after `done`. The bench also holds acknowledges back for several cycles. In those cycles the write port must keep its request unchanged.

// File: rtl/int_entry_pkg.sv
package int_entry_pkg;

    typedef enum logic [2:0] {
        SRC_SWINT = 3'd0,
        SRC_BRK   = 3'd1,
        SRC_OVF   = 3'd2,
        SRC_EXT   = 3'd3,
        SRC_EXC   = 3'd4
    } src_t;

    localparam logic [1:0] MD_REAL = 2'd0;
    localparam logic [1:0] MD_PROT = 2'd1;

    typedef enum logic [2:0] {
        IT_SS    = 3'd0,
        IT_RSP   = 3'd1,
        IT_FLAGS = 3'd2,
        IT_CS    = 3'd3,
        IT_RIP   = 3'd4,
        IT_ERR   = 3'd5
    } item_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_DONE = 2'd2
    } st_t;

endpackage

// File: rtl/int_vec_resolve.sv
module int_vec_resolve
    import int_entry_pkg::*;
#(
    parameter int          VEC_W    = 8,
    parameter int          ADDR_W   = 64,
    parameter int          RSV_N    = 32,
    parameter logic [31:0] ERR_MASK = 32'h0002_7D00
) (
    input  logic [2:0]        src,
    input  logic [VEC_W-1:0]  imm_vec,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] base,
    output logic [VEC_W-1:0]  vec,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              has_err
);
    localparam int RSV_B = $clog2(RSV_N);

    logic [2:0] sh;

    always_comb begin
        unique case (src)
            3'(SRC_BRK): vec = VEC_W'(3);
            3'(SRC_OVF): vec = VEC_W'(4);
            default:     vec = imm_vec;
        endcase
    end

    always_comb begin
        unique case (mode)
            MD_REAL: sh = 3'd2;
            MD_PROT: sh = 3'd3;
            default: sh = 3'd4;
        endcase
        desc_addr = base + (ADDR_W'(vec) << sh);
    end

    always_comb begin
        has_err = 1'b0;
        if (src == 3'(SRC_EXC) && vec < VEC_W'(RSV_N))
            has_err = ERR_MASK[vec[RSV_B-1:0]];
    end

endmodule

// File: rtl/int_push_plan.sv
module int_push_plan
    import int_entry_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       priv_change,
    input  logic       has_err,
    output item_t      first_item,
    output item_t      last_item,
    output logic       do_switch,
    output logic       wide
);
    always_comb begin
        wide       = mode[1];
        do_switch  = mode[1] | ((mode == MD_PROT) & priv_change);
        first_item = do_switch ? IT_SS : IT_FLAGS;
        last_item  = has_err ? IT_ERR : IT_RIP;
    end
endmodule

// File: rtl/int_item_mux.sv
module int_item_mux
    import int_entry_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int SEL_W  = 16,
    parameter int ERR_W  = 32
) (
    input  item_t             item,
    input  logic              wide,
    input  logic [SEL_W-1:0]  ss,
    input  logic [ADDR_W-1:0] rsp,
    input  logic [DATA_W-1:0] flags,
    input  logic [SEL_W-1:0]  cs,
    input  logic [ADDR_W-1:0] rip,
    input  logic [ERR_W-1:0]  err,
    output logic [DATA_W-1:0] data
);
    localparam int NARROW_W = 32;

    logic [DATA_W-1:0] raw;

    always_comb begin
        unique case (item)
            IT_SS:    raw = DATA_W'(ss);
            IT_RSP:   raw = DATA_W'(rsp);
            IT_FLAGS: raw = flags;
            IT_CS:    raw = DATA_W'(cs);
            IT_RIP:   raw = DATA_W'(rip);
            IT_ERR:   raw = DATA_W'(err);
            default:  raw = '0;
        endcase
        data = wide ? raw : DATA_W'(raw[NARROW_W-1:0]);
    end
endmodule

// File: rtl/int_entry_seq.sv
module int_entry_seq
    import int_entry_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64,
    parameter int SEL_W  = 16,
    parameter int ERR_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_src,
    input  logic [VEC_W-1:0]  req_vec,
    input  logic              req_fault,
    input  logic [1:0]        mode,
    input  logic              priv_change,
    input  logic [ADDR_W-1:0] idt_base,
    input  logic [SEL_W-1:0]  cur_ss,
    input  logic [ADDR_W-1:0] cur_rsp,
    input  logic [SEL_W-1:0]  cur_cs,
    input  logic [ADDR_W-1:0] cur_rip,
    input  logic [ADDR_W-1:0] next_rip,
    input  logic [DATA_W-1:0] cur_flags,
    input  logic [ERR_W-1:0]  err_code,
    input  logic [ADDR_W-1:0] new_rsp,
    output logic              busy,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_size8,
    input  logic              wr_ack,
    output logic              done,
    output logic [VEC_W-1:0]  done_vec,
    output logic [ADDR_W-1:0] done_desc_addr,
    output logic [ADDR_W-1:0] done_rsp,
    output logic              done_switch
);
    localparam logic [ADDR_W-1:0] SLOT_WIDE   = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] SLOT_NARROW = ADDR_W'(4);

    st_t state, nxt;

    logic [VEC_W-1:0]  a_vec;
    logic [ADDR_W-1:0] a_desc;
    logic              a_err;
    item_t             a_first, a_last;
    logic              a_switch, a_wide;
    logic              accept;

    logic [VEC_W-1:0]  r_vec;
    logic [ADDR_W-1:0] r_desc;
    item_t             r_last;
    item_t             idx;
    logic              r_switch, r_wide;
    logic [SEL_W-1:0]  r_ss, r_cs;
    logic [ADDR_W-1:0] r_rsp, r_rip, ptr;
    logic [DATA_W-1:0] r_flags;
    logic [ERR_W-1:0]  r_err;
    logic [ADDR_W-1:0] slot;
    logic [DATA_W-1:0] item_data;

    int_vec_resolve #(
        .VEC_W  (VEC_W),
        .ADDR_W (ADDR_W)
    ) u_vec (
        .src       (req_src),
        .imm_vec   (req_vec),
        .mode      (mode),
        .base      (idt_base),
        .vec       (a_vec),
        .desc_addr (a_desc),
        .has_err   (a_err)
    );

    int_push_plan u_plan (
        .mode        (mode),
        .priv_change (priv_change),
        .has_err     (a_err),
        .first_item  (a_first),
        .last_item   (a_last),
        .do_switch   (a_switch),
        .wide        (a_wide)
    );

    int_item_mux #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W),
        .ERR_W  (ERR_W)
    ) u_mux (
        .item  (idx),
        .wide  (r_wide),
        .ss    (r_ss),
        .rsp   (r_rsp),
        .flags (r_flags),
        .cs    (r_cs),
        .rip   (r_rip),
        .err   (r_err),
        .data  (item_data)
    );

    assign accept = req_valid && (state == ST_IDLE);
    assign slot   = r_wide ? SLOT_WIDE : SLOT_NARROW;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions: accept, ack-more, ack-last, release
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept) nxt = ST_PUSH;
            ST_PUSH: if (wr_ack && idx == r_last) nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy           = (state != ST_IDLE);
        wr_valid       = (state == ST_PUSH);
        done           = (state == ST_DONE);
        wr_addr        = ptr - slot;
        wr_data        = item_data;
        wr_size8       = r_wide;
        done_vec       = r_vec;
        done_desc_addr = r_desc;
        done_rsp       = ptr;
        done_switch    = r_switch;
    end

    // request capture and push walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_vec    <= '0;
            r_desc   <= '0;
            r_last   <= IT_RIP;
            idx      <= IT_FLAGS;
            r_switch <= 1'b0;
            r_wide   <= 1'b0;
            r_ss     <= '0;
            r_cs     <= '0;
            r_rsp    <= '0;
            r_rip    <= '0;
            r_flags  <= '0;
            r_err    <= '0;
            ptr      <= '0;
        end else if (accept) begin
            r_vec    <= a_vec;
            r_desc   <= a_desc;
            r_last   <= a_last;
            idx      <= a_first;
            r_switch <= a_switch;
            r_wide   <= a_wide;
            r_ss     <= cur_ss;
            r_cs     <= cur_cs;
            r_rsp    <= cur_rsp;
            r_rip    <= (req_src == 3'(SRC_EXC) && req_fault) ? cur_rip : next_rip;
            r_flags  <= cur_flags;
            r_err    <= err_code;
            ptr      <= a_switch ? new_rsp : cur_rsp;
        end else if (state == ST_PUSH && wr_ack) begin
            ptr <= ptr - slot;
            if (idx != r_last) idx <= item_t'(idx + 3'd1);
        end
    end

endmodule

// File: rtl/int_entry_seq_chk.sv
module int_entry_seq_chk #(
    parameter int ADDR_W = 64,
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              wr_valid,
    input logic              wr_ack,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_size8,
    input logic              done,
    input logic [ADDR_W-1:0] done_rsp
);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ack |=> wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_size8));

    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ack |=> done ||
            (wr_valid && wr_addr == $past(wr_addr) - (wr_size8 ? ADDR_W'(8) : ADDR_W'(4))));

    p_final_rsp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_valid && wr_ack) && done_rsp == $past(wr_addr));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !busy |=> busy);

    p_wr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy && !done);
endmodule

bind int_entry_seq int_entry_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .wr_valid  (wr_valid),
    .wr_ack    (wr_ack),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_size8  (wr_size8),
    .done      (done),
    .done_rsp  (done_rsp)
);

// File: tb/sim_int_entry_seq.sv
module sim_int_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_src = '0;
    logic [7:0]  req_vec = '0;
    logic        req_fault = 1'b0;
    logic [1:0]  mode = '0;
    logic        priv_change = 1'b0;
    logic [63:0] idt_base = 64'h0000_0000_0010_0000;
    logic [15:0] cur_ss = 16'h0023;
    logic [63:0] cur_rsp = 64'h0000_1234_0000_8000;
    logic [15:0] cur_cs = 16'h001B;
    logic [63:0] cur_rip = 64'hFFFF_8000_0040_1000;
    logic [63:0] next_rip = 64'hFFFF_8000_0040_1005;
    logic [63:0] cur_flags = 64'h0000_0001_0000_0246;
    logic [31:0] err_code = 32'hDEAD_0010;
    logic [63:0] new_rsp = 64'h0000_5678_0002_0000;
    logic        busy, wr_valid, wr_size8, done, done_switch;
    logic        wr_ack = 1'b0;
    logic [63:0] wr_addr, wr_data, done_desc_addr, done_rsp;
    logic [7:0]  done_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_vec(req_vec), .req_fault(req_fault), .mode(mode),
        .priv_change(priv_change), .idt_base(idt_base), .cur_ss(cur_ss),
        .cur_rsp(cur_rsp), .cur_cs(cur_cs), .cur_rip(cur_rip),
        .next_rip(next_rip), .cur_flags(cur_flags), .err_code(err_code),
        .new_rsp(new_rsp), .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_size8(wr_size8), .wr_ack(wr_ack), .done(done),
        .done_vec(done_vec), .done_desc_addr(done_desc_addr),
        .done_rsp(done_rsp), .done_switch(done_switch)
    );

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One event: compute the expectation from the requirements, run it, compare.
    task automatic run_case(string tag, logic [2:0] src, logic [7:0] imm, logic [1:0] md,
                            bit pc, bit flt, int dly, bit collide);
        logic [7:0]  ev;
        logic [63:0] edesc, start, slot;
        logic [63:0] exp_d [6];
        bit          wide, sw, err;
        int          n, nw, guard;
        logic [63:0] ret;

        ev    = (src == 3'd1) ? 8'd3 : (src == 3'd2) ? 8'd4 : imm;             // R1
        edesc = idt_base + (64'(ev) << ((md == 2'd0) ? 2 : (md == 2'd1) ? 3 : 4)); // R2
        wide  = md[1];
        sw    = wide || (md == 2'd1 && pc);                                     // R3 R4
        err   = (src == 3'd4) && (ev inside {8'd8, 8'd10, 8'd11, 8'd12, 8'd13, 8'd14, 8'd17}); // R5
        ret   = (src == 3'd4 && flt) ? cur_rip : next_rip;                      // R6
        slot  = wide ? 64'd8 : 64'd4;
        start = sw ? new_rsp : cur_rsp;
        n = 0;
        if (sw) begin
            exp_d[n++] = 64'(cur_ss);
            exp_d[n++] = cur_rsp;
        end
        exp_d[n++] = cur_flags;
        exp_d[n++] = 64'(cur_cs);
        exp_d[n++] = ret;
        if (err) exp_d[n++] = 64'(err_code);
        if (!wide) for (int i = 0; i < n; i++) exp_d[i] = 64'(exp_d[i][31:0]); // R7

        @(negedge clk);
        req_src = src; req_vec = imm; mode = md; priv_change = pc; req_fault = flt;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_vec = imm ^ 8'h5A;
        chk({tag, " R9"}, "busy after accept", 64'(busy), 64'd1);

        nw = 0;
        guard = 0;
        while (!done && guard < 200) begin
            guard++;
            if (wr_valid) begin
                logic [63:0] a0, d0;
                a0 = wr_addr; d0 = wr_data;
                if (nw < n) begin
                    chk({tag, " R7"}, "wr_addr", a0, start - slot * 64'(nw + 1));
                    chk({tag, (nw < 2 && sw) ? " R4" : (nw == n - 1 && err) ? " R5" : " R3"},
                        "wr_data", d0, exp_d[nw]);
                    chk({tag, " R7"}, "wr_size8", 64'(wr_size8), 64'(wide));
                end
                for (int k = 0; k < dly; k++) begin
                    @(negedge clk);
                    chk({tag, " R8"}, "held request", {63'd0, wr_valid && wr_addr == a0 && wr_data == d0}, 64'd1);
                end
                wr_ack = 1'b1;
                if (collide && nw == n - 1) begin
                    req_valid = 1'b1;
                    req_vec = 8'hC3;
                    req_src = 3'd0;
                end
                nw++;
                @(negedge clk);
                wr_ack = 1'b0;
                req_valid = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk({tag, " R5"}, "write count", 64'(nw), 64'(n));
        chk({tag, " R9"}, "done", 64'(done), 64'd1);
        chk({tag, " R1"}, "done_vec", 64'(done_vec), 64'(ev));
        chk({tag, " R2"}, "done_desc_addr", done_desc_addr, edesc);
        chk({tag, " R7"}, "done_rsp", done_rsp, start - slot * 64'(n));
        chk({tag, sw ? " R4" : " R3"}, "done_switch", 64'(done_switch), 64'(sw));
        @(negedge clk);
        chk({tag, " R9"}, "done one cycle", 64'(done), 64'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk({tag, " R9"}, "idle after done", {62'd0, busy, wr_valid}, 64'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R10", "busy in reset", 64'(busy), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "idle outputs", {61'd0, busy, wr_valid, done}, 64'd0);

        run_case("int_n prot same",    3'd0, 8'h40, 2'd1, 1'b0, 1'b0, 0, 1'b0);
        run_case("brk long",           3'd1, 8'h99, 2'd2, 1'b0, 1'b0, 2, 1'b0);
        run_case("ovf real pc ignored",3'd2, 8'h77, 2'd0, 1'b1, 1'b0, 1, 1'b0);
        run_case("page fault long",    3'd4, 8'd14, 2'd3, 1'b0, 1'b1, 0, 1'b0);
        run_case("gp prot switch",     3'd4, 8'd13, 2'd1, 1'b1, 1'b1, 3, 1'b0);
        run_case("ud prot fault",      3'd4, 8'd6,  2'd1, 1'b0, 1'b1, 0, 1'b0);
        run_case("ext vec14 long",     3'd3, 8'd14, 2'd2, 1'b0, 1'b1, 0, 1'b0);
        run_case("int_n vec8 prot",    3'd0, 8'd8,  2'd1, 1'b1, 1'b0, 1, 1'b0);
        run_case("ac trap real",       3'd4, 8'd17, 2'd0, 1'b0, 1'b0, 0, 1'b0);
        run_case("collide last ack",   3'd4, 8'd10, 2'd2, 1'b0, 1'b1, 1, 1'b1);
        run_case("ext high vec prot",  3'd3, 8'hFF, 2'd1, 1'b0, 1'b0, 0, 1'b1);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule